// File: doc/BRIEF.md
# UART Host Register File with Interrupt Identification

This block is the processor-facing side of a 16550-compatible serial port. A host issues single-cycle read or write accesses on a 3-bit offset. The block keeps the interrupt-enable, line-control, modem-control, FIFO-control, scratch and baud-divisor registers. It builds the line-status, modem-status and interrupt-identification values when they are read, and it applies the side effects of those reads. Bit 7 of the line-control register switches offsets 0 and 1 over to the two divisor bytes.

The transmit side is treated as always ready. Each data write outside loopback leaves the block as a one-cycle byte strobe. Received bytes enter an internal receive queue. The queue holds one byte while FIFO mode is off, and it holds the full parameterised depth while FIFO mode is on. In loopback mode the host's data writes feed that queue in place of the serial input. A level interrupt output is derived from the current register state through a fixed four-level priority. Read data is registered and appears in the cycle after the access.

Top module: `uart_host_regs`

## Requirements
- R1: After reset the divisor reads 12 (offset 0 gives 0x0C and offset 1 gives 0x00 with bit 7 of the line-control register set), irq_o is low, tx_valid_o is low and acc_rdata_o is 0x00.
- R2: With line-control bit 7 set, offsets 0 and 1 read and write the divisor low and high bytes. With it clear, the same offsets reach the data port and the interrupt-enable register, and the divisor is left alone.
- R3: Interrupt-enable writes keep only bits 3:0 (0 receive, 1 transmit-empty, 2 line status, 3 modem). Modem-control writes keep only bits 4:0 (0 DTR, 1 RTS, 2 OUT1, 3 OUT2, 4 loopback).
- R4: Outside loopback, a data write drives tx_valid_o high with tx_byte_o equal to the written byte for exactly the following cycle. Every data write sets the transmit-empty pending flag.
- R5: Offset 2 reads return the interrupt reason in bits 3:0, highest priority first: 0x6 for overrun with enable bit 2, 0x4 for a non-empty queue with enable bit 0, 0x2 for transmit-empty pending with enable bit 1, 0x0 for any modem delta with enable bit 3, and 0x1 when none applies. irq_o is high exactly when a reason other than 0x1 applies.
- R6: A reason read that reports 0x2 clears the transmit-empty pending flag. A reason read that reports any other code leaves the flag set.
- R7: Bits 7:6 of the reason read are 11 while FIFO-control bit 0 is set and 00 otherwise. Bits 5:4 are always 0.
- R8: An offset 5 read returns bit 6 and bit 5 set, bit 1 equal to the overrun flag and bit 0 set when the queue is non-empty. The read then clears the overrun flag. A rejected push in the same cycle leaves the flag set.
- R9: An offset 2 write with bit 0 clear sets the FIFO-control register to zero, which gives a one-byte queue. With bit 0 set it keeps bits 0, 3, 7 and 6, and a set bit 1 empties the queue. Any change of bit 0 also empties the queue.
- R10: In loopback, a data write pushes the byte into the queue and produces no transmit strobe. A push to a full queue sets the overrun flag. rx_valid_i is ignored.
- R11: Outside loopback, rx_valid_i pushes rx_byte_i. A push to a full queue sets the overrun flag, unless a host read of offset 0 pops the queue in the same cycle, in which case the byte is accepted.
- R12: Modem-status bits 7:4 are {OUT2, OUT1, DTR, RTS} in loopback and 0xA in normal mode. A modem-control write sets delta bit 0, 1 or 3 when the CTS, DSR or DCD line changes, and sets delta bit 2 when RI falls. An offset 6 read clears the deltas after returning them.
- R13: Writes to offsets 5 and 6 change nothing. An offset 0 read pops and returns the oldest queued byte, or returns 0xFF when the queue is empty.
- R14: The line-control and scratch registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en_i | input | 1 | Host access in this cycle |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 3 | Register offset |
| acc_wdata_i | input | 8 | Write data |
| acc_rdata_o | output | 8 | Read data, valid the cycle after a read |
| tx_valid_o | output | 1 | One-cycle transmit byte strobe |
| tx_byte_o | output | 8 | Transmitted byte |
| rx_valid_i | input | 1 | Received byte present |
| rx_byte_i | input | 8 | Received byte |
| irq_o | output | 1 | Level interrupt request |

## Verification
Two operations can land in the same cycle: a serial-side push from rx_valid_i and a host read of offset 0 that pops the queue. The bench fills the FIFO-mode queue to its depth and confirms that an extra push sets overrun. It then clears the flag, raises rx_valid_i in the very cycle of a data read, and requires the line status to show no overrun. It also requires the pushed byte to come out last after all the older bytes have drained in order.

// File: rtl/uart_hr_pkg.sv
package uart_hr_pkg;

    typedef enum logic [2:0] {
        OFF_DATA = 3'd0,
        OFF_IER  = 3'd1,
        OFF_IIR  = 3'd2,
        OFF_LCR  = 3'd3,
        OFF_MCR  = 3'd4,
        OFF_LSR  = 3'd5,
        OFF_MSR  = 3'd6,
        OFF_SCR  = 3'd7
    } reg_off_e;

    // interrupt reason codes reported in the low nibble of the reason read
    localparam logic [3:0] WHY_NONE  = 4'h1;
    localparam logic [3:0] WHY_LINE  = 4'h6;
    localparam logic [3:0] WHY_RXD   = 4'h4;
    localparam logic [3:0] WHY_TXE   = 4'h2;
    localparam logic [3:0] WHY_MODEM = 4'h0;

    typedef struct packed {
        logic [7:0] dll;
        logic [7:0] dlh;
        logic [3:0] ier;
        logic [7:0] lcr;
        logic [4:0] mcr;
        logic [3:0] dlt;
        logic [7:0] fcr;
        logic [7:0] scr;
        logic       oe;
        logic       thre;
        logic [7:0] rdata;
        logic       txv;
        logic [7:0] txb;
    } regs_t;

    // modem line levels {DCD, RI, DSR, CTS} seen for a given control value
    function automatic logic [3:0] modem_lines(input logic [4:0] mcr);
        if (mcr[4]) begin
            return {mcr[3], mcr[2], mcr[0], mcr[1]};
        end
        return 4'b1010;
    endfunction

endpackage

// File: rtl/uart_hr_rxq.sv
module uart_hr_rxq #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       deep_i,
    input  logic       flush_i,
    input  logic       push_i,
    input  logic [7:0] push_data_i,
    input  logic       pop_i,
    output logic [7:0] head_o,
    output logic       nonempty_o,
    output logic       accept_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } qstate_t;

    qstate_t    st_d, st_q;
    logic [7:0] mem [DEPTH];
    logic [CW-1:0] cap;
    logic       full, do_pop, accept;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d   = st_q;
        cap    = deep_i ? CW'(DEPTH) : CW'(1);
        full   = (st_q.cnt >= cap);
        do_pop = pop_i && (st_q.cnt != '0) && !flush_i;
        accept = push_i && !flush_i && (!full || do_pop);
        if (flush_i) begin
            st_d = '0;
        end else begin
            if (accept) st_d.wp = bump(st_q.wp);
            if (do_pop) st_d.rp = bump(st_q.rp);
            st_d.cnt = st_q.cnt + CW'(accept) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem[st_q.wp] <= push_data_i;
    end

    assign head_o     = mem[st_q.rp];
    assign nonempty_o = (st_q.cnt != '0);
    assign accept_o   = accept;

endmodule

// File: rtl/uart_hr_irq_sel.sv
module uart_hr_irq_sel
    import uart_hr_pkg::*;
(
    input  logic [3:0] ier_i,
    input  logic       overrun_i,
    input  logic       rx_ready_i,
    input  logic       tx_pend_i,
    input  logic       modem_delta_i,
    output logic [3:0] why_o,
    output logic       active_o
);
    localparam int NSRC = 4;

    logic [NSRC-1:0] hit;
    logic [3:0]      code [NSRC];

    // index 0 is the highest priority
    assign hit[0] = overrun_i     && ier_i[2];
    assign hit[1] = rx_ready_i    && ier_i[0];
    assign hit[2] = tx_pend_i     && ier_i[1];
    assign hit[3] = modem_delta_i && ier_i[3];

    assign code[0] = WHY_LINE;
    assign code[1] = WHY_RXD;
    assign code[2] = WHY_TXE;
    assign code[3] = WHY_MODEM;

    always_comb begin
        why_o = WHY_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (hit[i]) why_o = code[i];
        end
    end

    assign active_o = |hit;

endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
    import uart_hr_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int REF_CLK_HZ = 1843200,
    parameter int BAUD       = 9600,
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_en_i,
    input  logic       acc_wr_i,
    input  logic [2:0] acc_addr_i,
    input  logic [7:0] acc_wdata_i,
    output logic [7:0] acc_rdata_o,
    output logic       tx_valid_o,
    output logic [7:0] tx_byte_o,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_byte_i,
    output logic       irq_o
);
    localparam int          DIVISOR = REF_CLK_HZ / (BAUD * OVERSAMPLE);
    localparam logic [15:0] DIV16   = 16'(DIVISOR);

    regs_t      r_d, r_q;
    logic       q_flush, q_push, q_pop, q_accept, q_nonempty;
    logic [7:0] q_pdata, q_head;
    logic [3:0] why;
    logic       irq_act;
    logic       dlab, loop;
    logic [3:0] lines_old, lines_new;

    uart_hr_rxq #(.DEPTH(FIFO_DEPTH)) u_rxq (
        .clk        (clk),
        .rst_n      (rst_n),
        .deep_i     (r_q.fcr[0]),
        .flush_i    (q_flush),
        .push_i     (q_push),
        .push_data_i(q_pdata),
        .pop_i      (q_pop),
        .head_o     (q_head),
        .nonempty_o (q_nonempty),
        .accept_o   (q_accept)
    );

    uart_hr_irq_sel u_sel (
        .ier_i        (r_q.ier),
        .overrun_i    (r_q.oe),
        .rx_ready_i   (q_nonempty),
        .tx_pend_i    (r_q.thre),
        .modem_delta_i(|r_q.dlt),
        .why_o        (why),
        .active_o     (irq_act)
    );

    assign dlab      = r_q.lcr[7];
    assign loop      = r_q.mcr[4];
    assign lines_old = modem_lines(r_q.mcr);
    assign lines_new = modem_lines(acc_wdata_i[4:0]);

    always_comb begin
        r_d     = r_q;
        r_d.txv = 1'b0;
        q_flush = 1'b0;
        q_pop   = 1'b0;
        q_push  = rx_valid_i && !loop;
        q_pdata = rx_byte_i;

        if (acc_en_i && acc_wr_i) begin
            if (dlab && acc_addr_i == OFF_DATA) begin
                r_d.dll = acc_wdata_i;
            end else if (dlab && acc_addr_i == OFF_IER) begin
                r_d.dlh = acc_wdata_i;
            end else begin
                case (reg_off_e'(acc_addr_i))
                    OFF_DATA: begin
                        if (loop) begin
                            q_push  = 1'b1;
                            q_pdata = acc_wdata_i;
                        end else begin
                            r_d.txv = 1'b1;
                            r_d.txb = acc_wdata_i;
                        end
                        r_d.thre = 1'b1;
                    end
                    OFF_IER: r_d.ier = acc_wdata_i[3:0];
                    OFF_IIR: begin
                        if (r_q.fcr[0] ^ acc_wdata_i[0]) q_flush = 1'b1;
                        if (!acc_wdata_i[0]) begin
                            r_d.fcr = 8'h00;
                        end else begin
                            if (acc_wdata_i[1]) q_flush = 1'b1;
                            r_d.fcr = acc_wdata_i & 8'hC9;
                        end
                    end
                    OFF_LCR: r_d.lcr = acc_wdata_i;
                    OFF_MCR: begin
                        r_d.mcr    = acc_wdata_i[4:0];
                        r_d.dlt[0] = r_q.dlt[0] | (lines_old[0] ^ lines_new[0]);
                        r_d.dlt[1] = r_q.dlt[1] | (lines_old[1] ^ lines_new[1]);
                        r_d.dlt[2] = r_q.dlt[2] | (lines_old[2] & ~lines_new[2]);
                        r_d.dlt[3] = r_q.dlt[3] | (lines_old[3] ^ lines_new[3]);
                    end
                    OFF_SCR: r_d.scr = acc_wdata_i;
                    default: ;
                endcase
            end
        end else if (acc_en_i) begin
            if (dlab && acc_addr_i == OFF_DATA) begin
                r_d.rdata = r_q.dll;
            end else if (dlab && acc_addr_i == OFF_IER) begin
                r_d.rdata = r_q.dlh;
            end else begin
                case (reg_off_e'(acc_addr_i))
                    OFF_DATA: begin
                        q_pop     = q_nonempty;
                        r_d.rdata = q_nonempty ? q_head : 8'hFF;
                    end
                    OFF_IER: r_d.rdata = {4'h0, r_q.ier};
                    OFF_IIR: begin
                        r_d.rdata = {r_q.fcr[0] ? 2'b11 : 2'b00, 2'b00, why};
                        if (why == WHY_TXE) r_d.thre = 1'b0;
                    end
                    OFF_LCR: r_d.rdata = r_q.lcr;
                    OFF_MCR: r_d.rdata = {3'b000, r_q.mcr};
                    OFF_LSR: begin
                        r_d.rdata = {1'b0, 2'b11, 3'b000, r_q.oe, q_nonempty};
                        r_d.oe    = 1'b0;
                    end
                    OFF_MSR: begin
                        r_d.rdata = {lines_old, r_q.dlt};
                        r_d.dlt   = 4'h0;
                    end
                    OFF_SCR: r_d.rdata = r_q.scr;
                    default: r_d.rdata = 8'hFF;
                endcase
            end
        end

        // a rejected push outranks a same-cycle status read
        if (q_push && !q_flush && !q_accept) r_d.oe = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.dll <= DIV16[7:0];
            r_q.dlh <= DIV16[15:8];
        end else begin
            r_q <= r_d;
        end
    end

    assign acc_rdata_o = r_q.rdata;
    assign tx_valid_o  = r_q.txv;
    assign tx_byte_o   = r_q.txb;
    assign irq_o       = irq_act;

endmodule

// File: rtl/uart_hr_chk.sv
module uart_hr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_en_i,
    input logic       acc_wr_i,
    input logic [2:0] acc_addr_i,
    input logic [7:0] acc_rdata_o,
    input logic       tx_valid_o,
    input logic       irq_o
);
    // R4: a transmit strobe only follows a write to offset 0
    assert_tx_from_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> $past(acc_en_i && acc_wr_i && acc_addr_i == 3'd0));

    // R5: with no request pending the reason read reports 0x1
    assert_idle_reason_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && !acc_wr_i && acc_addr_i == 3'd2 && !irq_o) |=> acc_rdata_o[3:0] == 4'h1);

    // R5: with a request pending, bit 0 of the reason read is low
    assert_busy_reason_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && !acc_wr_i && acc_addr_i == 3'd2 && irq_o) |=> !acc_rdata_o[0]);

    // R7: bits 5:4 of the reason read are always zero
    assert_reason_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && !acc_wr_i && acc_addr_i == 3'd2) |=> acc_rdata_o[5:4] == 2'b00);

    // R8: a line status read shows both transmit-ready bits
    assert_lsr_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && !acc_wr_i && acc_addr_i == 3'd5 && !acc_wr_i) |=> acc_rdata_o[6:5] == 2'b11);

    // R13: a write never disturbs the read data
    assert_write_keeps_rdata_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && acc_wr_i) |=> $stable(acc_rdata_o));

endmodule

bind uart_host_regs uart_hr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en_i   (acc_en_i),
    .acc_wr_i   (acc_wr_i),
    .acc_addr_i (acc_addr_i),
    .acc_rdata_o(acc_rdata_o),
    .tx_valid_o (tx_valid_o),
    .irq_o      (irq_o)
);

// File: tb/uart_host_regs_tb.sv
module uart_host_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en_i = 1'b0, acc_wr_i = 1'b0;
    logic [2:0] acc_addr_i = '0;
    logic [7:0] acc_wdata_i = '0;
    logic [7:0] acc_rdata_o;
    logic       tx_valid_o;
    logic [7:0] tx_byte_o;
    logic       rx_valid_i = 1'b0;
    logic [7:0] rx_byte_i = '0;
    logic       irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_host_regs u_dut (
        .clk(clk), .rst_n(rst_n),
        .acc_en_i(acc_en_i), .acc_wr_i(acc_wr_i), .acc_addr_i(acc_addr_i),
        .acc_wdata_i(acc_wdata_i), .acc_rdata_o(acc_rdata_o),
        .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o),
        .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .irq_o(irq_o)
    );

    // {req, wr, offset, wdata, expected read}
    localparam int NV = 27;
    localparam logic [23:0] VEC [NV] = '{
        {4'd14, 1'b0, 3'd3, 8'h00, 8'h00},  // R14 line control after reset
        {4'd0,  1'b1, 3'd3, 8'h80, 8'h00},
        {4'd1,  1'b0, 3'd0, 8'h00, 8'h0C},  // R1 divisor low
        {4'd1,  1'b0, 3'd1, 8'h00, 8'h00},  // R1 divisor high
        {4'd0,  1'b1, 3'd0, 8'h34, 8'h00},
        {4'd0,  1'b1, 3'd1, 8'h12, 8'h00},
        {4'd2,  1'b0, 3'd0, 8'h00, 8'h34},  // R2
        {4'd2,  1'b0, 3'd1, 8'h00, 8'h12},  // R2
        {4'd0,  1'b1, 3'd3, 8'h03, 8'h00},
        {4'd14, 1'b0, 3'd3, 8'h00, 8'h03},  // R14
        {4'd2,  1'b0, 3'd1, 8'h00, 8'h00},  // R2 enable register untouched
        {4'd0,  1'b1, 3'd1, 8'hFF, 8'h00},
        {4'd3,  1'b0, 3'd1, 8'h00, 8'h0F},  // R3
        {4'd0,  1'b1, 3'd4, 8'hFF, 8'h00},
        {4'd3,  1'b0, 3'd4, 8'h00, 8'h1F},  // R3
        {4'd12, 1'b0, 3'd6, 8'h00, 8'hF1},  // R12 loopback lines, CTS delta
        {4'd12, 1'b0, 3'd6, 8'h00, 8'hF0},  // R12 deltas cleared
        {4'd0,  1'b1, 3'd4, 8'h00, 8'h00},
        {4'd12, 1'b0, 3'd6, 8'h00, 8'hA5},  // R12 CTS change, RI fall
        {4'd0,  1'b1, 3'd7, 8'h5A, 8'h00},
        {4'd14, 1'b0, 3'd7, 8'h00, 8'h5A},  // R14 scratch
        {4'd0,  1'b1, 3'd5, 8'hFF, 8'h00},
        {4'd13, 1'b0, 3'd5, 8'h00, 8'h60},  // R13 status write ignored
        {4'd0,  1'b1, 3'd6, 8'hFF, 8'h00},
        {4'd13, 1'b0, 3'd6, 8'h00, 8'hA0},  // R13 modem write ignored
        {4'd0,  1'b1, 3'd1, 8'h00, 8'h00},
        {4'd5,  1'b0, 3'd2, 8'h00, 8'h01}   // R5 nothing pending
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_en_i = 1'b1; acc_wr_i = wr; acc_addr_i = a; acc_wdata_i = d;
        @(negedge clk);
        acc_en_i = 1'b0; acc_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag, input logic [7:0] exp);
        acc(1'b0, a, 8'h00);
        chk(tag, acc_rdata_o, exp);
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        rx_valid_i = 1'b1; rx_byte_i = b;
        @(negedge clk);
        rx_valid_i = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq", {7'b0, irq_o}, 8'h00);
        chk("R1 tx_valid", {7'b0, tx_valid_o}, 8'h00);
        chk("R1 rdata", acc_rdata_o, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            v = VEC[i];
            acc(v[19], v[18:16], v[15:8]);
            if (!v[19]) chk($sformatf("R%0d vector %0d", v[23:20], i), acc_rdata_o, v[7:0]);
        end

        // R4 transmit strobe
        acc(1'b1, 3'd0, 8'h41);
        chk("R4 strobe", {7'b0, tx_valid_o}, 8'h01);
        chk("R4 byte", tx_byte_o, 8'h41);
        @(negedge clk);
        chk("R4 one cycle", {7'b0, tx_valid_o}, 8'h00);
        chk("R5 masked irq", {7'b0, irq_o}, 8'h00);
        acc(1'b1, 3'd1, 8'h02);
        chk("R5 tx irq", {7'b0, irq_o}, 8'h01);
        rd(3'd2, "R5 tx reason", 8'h02);
        chk("R6 irq cleared", {7'b0, irq_o}, 8'h00);
        rd(3'd2, "R6 flag cleared", 8'h01);

        // R10 loopback with a one-byte queue
        acc(1'b1, 3'd4, 8'h10);
        acc(1'b1, 3'd1, 8'h0F);
        rd(3'd2, "R5 modem reason", 8'h00);
        acc(1'b1, 3'd0, 8'h77);
        chk("R10 no strobe", {7'b0, tx_valid_o}, 8'h00);
        rd(3'd2, "R5 rx over tx", 8'h04);
        acc(1'b1, 3'd0, 8'h88);
        rd(3'd2, "R5 line highest", 8'h06);
        rd(3'd5, "R8 overrun shown", 8'h63);
        rd(3'd5, "R8 overrun cleared", 8'h61);
        rd(3'd0, "R13 pop", 8'h77);
        rd(3'd2, "R6 tx kept", 8'h02);
        rd(3'd2, "R5 modem after tx", 8'h00);
        rd(3'd6, "R12 loopback deltas", 8'h0A);
        rd(3'd2, "R5 none", 8'h01);
        rd(3'd0, "R13 empty read", 8'hFF);
        rx_push(8'h55);
        rd(3'd5, "R10 rx ignored", 8'h60);

        // R11 FIFO mode, full queue and same-cycle push with pop
        acc(1'b1, 3'd4, 8'h00);
        acc(1'b0, 3'd6, 8'h00);
        acc(1'b1, 3'd2, 8'hCF);
        rd(3'd2, "R7 fifo flag", 8'hC1);
        for (int i = 0; i < 16; i++) rx_push(8'h10 + 8'(i));
        rd(3'd5, "R11 full no overrun", 8'h61);
        rx_push(8'hDD);
        rd(3'd5, "R11 overrun", 8'h63);
        @(negedge clk);
        rx_valid_i = 1'b1; rx_byte_i = 8'hEE;
        acc_en_i = 1'b1; acc_wr_i = 1'b0; acc_addr_i = 3'd0;
        @(negedge clk);
        rx_valid_i = 1'b0; acc_en_i = 1'b0;
        chk("R11 pop head", acc_rdata_o, 8'h10);
        rd(3'd5, "R11 push with pop", 8'h61);
        for (int i = 1; i < 16; i++) rd(3'd0, "R11 order", 8'h10 + 8'(i));
        rd(3'd0, "R11 late byte", 8'hEE);
        rd(3'd5, "R11 drained", 8'h60);

        // R9 FIFO control
        rx_push(8'h01);
        rx_push(8'h02);
        acc(1'b1, 3'd2, 8'hC3);
        rd(3'd5, "R9 receive reset", 8'h60);
        rx_push(8'h03);
        acc(1'b1, 3'd2, 8'h00);
        rd(3'd5, "R9 mode change flush", 8'h60);
        rd(3'd2, "R7 fifo off", 8'h01);
        rx_push(8'h04);
        rx_push(8'h05);
        rd(3'd5, "R9 one byte depth", 8'h63);
        acc(1'b1, 3'd2, 8'h01);
        rd(3'd5, "R9 enable flush", 8'h60);
        rd(3'd2, "R7 fifo on", 8'hC1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule